// File: doc/BRIEF.md
# Stereo Multi-Form PWM Output Stage

This block turns one short quantized sample per stereo channel into pulse-width-modulated drive on four pins, two per channel. The second pin of each pair carries the complement of the first, so an external bridge power stage or a headphone path can use the pair as a differential drive. Each sample is a two's complement number that is mapped to offset binary. A zero sample therefore gives 50% duty. One PWM period holds 2^N counter steps for N-bit data.

A 2-bit form field picks the pulse shape:
- `00`: the pulse is anchored to the start of the period.
- `01`: the pulse is centred in the period.
- `10`: left and right are mirrored. The left pulse starts the period and the right pulse ends it.
- `11`: both pulses are anchored to the end of the period.

A 2-bit rate field picks the period rate and the sample width together. The block also provides:
- a 50%-duty mute, either common to both channels or per channel;
- an absolute-zero mute that silences every pin;
- a left/right exchange at the pins;
- an exchange of the two right-channel pins that applies only in power-stage use.

All controls and samples are captured at a period boundary, so a change never produces a runt pulse.

Top module: `stereo_pwm_out`

## Requirements
- R1: A sample s maps to duty value v = s XOR (sign bit set), so v ranges over 0..2^N-1. A zero sample gives v = 2^(N-1), which is 50% duty. The period holds 2^N counter steps, and counter value c runs from 0.
- R2: Rate field encodings (DW = 6):
  - `00` and `11`: 6-bit samples, one counter step per clock, 64 clocks per period.
  - `01`: 5-bit samples taken from bits [4:0], one step every 2 clocks, 64 clocks per period.
  - `10`: 5-bit samples, one step per clock, 32 clocks per period.
- R3: Form `00` (edge): the first pin of a channel is high while c < v.
- R4: Form `01` (centre): with st = floor((P-v)/2), where P is the period length in counter steps, the pin is high while st <= c < st+v.
- R5: Form `10` (mirrored): left is high while c < v, and right is high while c >= P-v.
- R6: Form `11` (trailing): both channels are high while c >= P-v.
- R7: 50%-duty mute forces a channel high while c < P/2 and low otherwise. It applies to both channels when `spk_mute_n` is low or `mute_both` is high. `mute_left` and `mute_right` apply it to one channel only.
- R8: When `zero_mute` is high, all four pins are low.
- R9: Outside absolute-zero mute, `out_l2` is always the complement of `out_l1`, and `out_r2` is always the complement of `out_r1`.
- R10: When `lr_swap` is high, the left pin pair carries the right channel and the right pin pair carries the left channel.
- R11: `r_pair_swap` exchanges `out_r1` and `out_r2` only while `power_stage` is high. It is applied after the left/right exchange.
- R12: Samples and all settings are captured only at the first clock of a period. The first clock after reset counts as a period start.
- R13: Synchronous active-high reset drives all pins low. The pins are registered and follow the counter with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM master clock |
| rst | input | 1 | Synchronous active-high reset |
| form_sel | input | 2 | Pulse shape select |
| rate_sel | input | 2 | Period rate and sample width select |
| smp_l | input | 6 | Left sample, two's complement |
| smp_r | input | 6 | Right sample, two's complement |
| spk_mute_n | input | 1 | Common 50% mute, active low |
| mute_both | input | 1 | Common 50% mute, register bit |
| mute_left | input | 1 | Left-only 50% mute |
| mute_right | input | 1 | Right-only 50% mute |
| zero_mute | input | 1 | Absolute-zero mute |
| lr_swap | input | 1 | Exchange left and right pin pairs |
| r_pair_swap | input | 1 | Exchange the two right pins |
| power_stage | input | 1 | High for power-stage use, low for headphone |
| out_l1 | output | 1 | Left drive, true phase |
| out_l2 | output | 1 | Left drive, complement |
| out_r1 | output | 1 | Right drive, true phase |
| out_r2 | output | 1 | Right drive, complement |

## Verification
A wrong counter or prescaler state moves the pulse edges and the period wrap. This shows on the pins within a single period, at most 64 clocks. A captured setting that goes stale or updates mid-period shows as a wrong shape or duty starting at the clock where the bench model's boundary and the design's boundary disagree. A broken complement or swap path shows on the very next clock, because every clock is compared against the reference model.

// File: rtl/stpwm_pkg.sv
package stpwm_pkg;
  typedef enum logic [1:0] {
    FORM_EDGE   = 2'b00,
    FORM_CENTER = 2'b01,
    FORM_MIRROR = 2'b10,
    FORM_TRAIL  = 2'b11
  } form_e;

  typedef struct packed {
    form_e form;
    logic  narrow;   // one bit fewer of sample data
    logic  half;     // counter steps every second clock
    logic  mute_l;
    logic  mute_r;
    logic  zero;
    logic  lr_swap;
    logic  r_swap;
    logic  power;
  } cfg_t;

  // rate field -> {narrow, half}
  function automatic logic [1:0] rate_decode(input logic [1:0] r);
    case (r)
      2'b01:   rate_decode = 2'b11;
      2'b10:   rate_decode = 2'b10;
      default: rate_decode = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/stpwm_timebase.sv
module stpwm_timebase #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow,
  input  logic          half,
  output logic [DW-1:0] cnt,
  output logic          start
);
  logic          pre;
  logic          tick;
  logic [DW-1:0] top;

  assign start = (cnt == '0) && !pre;
  assign tick  = !half || pre;
  assign top   = narrow ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pre <= 1'b0;
    end else begin
      pre <= half ? ~pre : 1'b0;
      if (tick) cnt <= (cnt == top) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stpwm_shaper.sv
module stpwm_shaper
  import stpwm_pkg::*;
#(
  parameter int DW    = 6,
  parameter int RIGHT = 0
) (
  input  logic [DW-1:0] smp,
  input  logic          narrow,
  input  form_e         form,
  input  logic          mute,
  input  logic [DW-1:0] cnt,
  output logic          lvl
);
  localparam int AW = DW + 1;

  logic [AW-1:0] v, p, c, st;
  logic          pulse;

  always_comb begin
    if (narrow) begin
      v = AW'({~smp[DW-2], smp[DW-3:0]});
      p = AW'(1) << (DW - 1);
    end else begin
      v = AW'({~smp[DW-1], smp[DW-2:0]});
      p = AW'(1) << DW;
    end
    c  = AW'(cnt);
    st = (p - v) >> 1;
    case (form)
      FORM_EDGE:   pulse = c < v;
      FORM_CENTER: pulse = (c >= st) && (c < st + v);
      FORM_MIRROR: pulse = (RIGHT != 0) ? (c >= p - v) : (c < v);
      default:     pulse = c >= p - v;
    endcase
    lvl = mute ? (c < (p >> 1)) : pulse;
  end
endmodule

// File: rtl/stpwm_router.sv
module stpwm_router (
  input  logic clk,
  input  logic rst,
  input  logic lvl_l,
  input  logic lvl_r,
  input  logic zero,
  input  logic lr_swap,
  input  logic r_swap,
  input  logic power,
  output logic out_l1,
  output logic out_l2,
  output logic out_r1,
  output logic out_r2
);
  logic [1:0] pair_l, pair_r, pin_l, pin_r;

  always_comb begin
    pair_l = {lvl_l, ~lvl_l};
    pair_r = {lvl_r, ~lvl_r};
    pin_l  = lr_swap ? pair_r : pair_l;
    pin_r  = lr_swap ? pair_l : pair_r;
    if (r_swap && power) pin_r = {pin_r[0], pin_r[1]};
    if (zero) begin
      pin_l = 2'b00;
      pin_r = 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) {out_l1, out_l2, out_r1, out_r2} <= 4'b0000;
    else     {out_l1, out_l2, out_r1, out_r2} <= {pin_l, pin_r};
  end
endmodule

// File: rtl/stereo_pwm_out.sv
module stereo_pwm_out
  import stpwm_pkg::*;
#(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    form_sel,
  input  logic [1:0]    rate_sel,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  input  logic          spk_mute_n,
  input  logic          mute_both,
  input  logic          mute_left,
  input  logic          mute_right,
  input  logic          zero_mute,
  input  logic          lr_swap,
  input  logic          r_pair_swap,
  input  logic          power_stage,
  output logic          out_l1,
  output logic          out_l2,
  output logic          out_r1,
  output logic          out_r2
);
  cfg_t          cfg_in, cfg_act, cfg_eff;
  logic [DW-1:0] smp_act [2];
  logic [DW-1:0] smp_eff [2];
  logic [DW-1:0] cnt;
  logic          start;
  logic [1:0]    lvl;
  logic          mute_common;

  assign mute_common = !spk_mute_n || mute_both;

  always_comb begin
    cfg_in.form              = form_e'(form_sel);
    {cfg_in.narrow, cfg_in.half} = rate_decode(rate_sel);
    cfg_in.mute_l            = mute_common || mute_left;
    cfg_in.mute_r            = mute_common || mute_right;
    cfg_in.zero              = zero_mute;
    cfg_in.lr_swap           = lr_swap;
    cfg_in.r_swap            = r_pair_swap;
    cfg_in.power             = power_stage;
    cfg_eff                  = start ? cfg_in : cfg_act;
    smp_eff[0]               = start ? smp_l : smp_act[0];
    smp_eff[1]               = start ? smp_r : smp_act[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_act    <= '0;
      smp_act[0] <= '0;
      smp_act[1] <= '0;
    end else begin
      cfg_act    <= cfg_eff;
      smp_act[0] <= smp_eff[0];
      smp_act[1] <= smp_eff[1];
    end
  end

  stpwm_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst(rst), .narrow(cfg_eff.narrow), .half(cfg_eff.half),
    .cnt(cnt), .start(start)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    stpwm_shaper #(.DW(DW), .RIGHT(ch)) u_sh (
      .smp(smp_eff[ch]), .narrow(cfg_eff.narrow), .form(cfg_eff.form),
      .mute((ch == 0) ? cfg_eff.mute_l : cfg_eff.mute_r),
      .cnt(cnt), .lvl(lvl[ch])
    );
  end

  stpwm_router u_rt (
    .clk(clk), .rst(rst), .lvl_l(lvl[0]), .lvl_r(lvl[1]),
    .zero(cfg_eff.zero), .lr_swap(cfg_eff.lr_swap), .r_swap(cfg_eff.r_swap),
    .power(cfg_eff.power),
    .out_l1(out_l1), .out_l2(out_l2), .out_r1(out_r1), .out_r2(out_r2)
  );
endmodule

// File: rtl/stereo_pwm_out_chk.sv
module stereo_pwm_out_chk #(
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          out_l1,
  input logic          out_l2,
  input logic          out_r1,
  input logic          out_r2,
  input logic          zero_now,
  input logic          narrow_now,
  input logic [DW-1:0] cnt
);
  // R13: reset clears all pins
  a_r13_reset_low: assert property (@(posedge clk)
    rst |=> ({out_l1, out_l2, out_r1, out_r2} == 4'b0000));

  // R8: absolute-zero mute silences every pin on the next clock
  a_r8_zero_silent: assert property (@(posedge clk) disable iff (rst)
    zero_now |=> ({out_l1, out_l2, out_r1, out_r2} == 4'b0000));

  // R9: pins are complementary pairs unless fully silent
  a_r9_pairs: assert property (@(posedge clk) disable iff (rst)
    ({out_l1, out_l2, out_r1, out_r2} == 4'b0000) ||
    ((out_l1 ^ out_l2) && (out_r1 ^ out_r2)));

  // R2: narrow data keeps the counter within half the wide range
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    narrow_now |-> (cnt < DW'(1 << (DW - 1))));
endmodule

bind stereo_pwm_out stereo_pwm_out_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .out_l1(out_l1), .out_l2(out_l2),
  .out_r1(out_r1), .out_r2(out_r2), .zero_now(cfg_eff.zero),
  .narrow_now(cfg_eff.narrow), .cnt(cnt)
);

// File: tb/test_stereo_pwm_out.sv
module test_stereo_pwm_out;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 6;

  logic clk = 0, rst = 1;
  logic [1:0] form_sel = 0, rate_sel = 0;
  logic [DW-1:0] smp_l = 0, smp_r = 0;
  logic spk_mute_n = 1, mute_both = 0, mute_left = 0, mute_right = 0;
  logic zero_mute = 0, lr_swap = 0, r_pair_swap = 0, power_stage = 0;
  logic out_l1, out_l2, out_r1, out_r2;

  int checks = 0, fails = 0;
  string cur_tag = "R13";
  logic [3:0] expq[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_pwm_out #(.DW(DW)) i_stereo_pwm_out (
    .clk(clk), .rst(rst), .form_sel(form_sel), .rate_sel(rate_sel),
    .smp_l(smp_l), .smp_r(smp_r), .spk_mute_n(spk_mute_n),
    .mute_both(mute_both), .mute_left(mute_left), .mute_right(mute_right),
    .zero_mute(zero_mute), .lr_swap(lr_swap), .r_pair_swap(r_pair_swap),
    .power_stage(power_stage), .out_l1(out_l1), .out_l2(out_l2),
    .out_r1(out_r1), .out_r2(out_r2)
  );

  task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pins(l1,l2,r1,r2) actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  // reference level from the requirements (R1, R3..R7)
  function automatic bit ref_lvl(int form, bit right, int v, int p, int c, bit mute);
    int st;
    if (mute) return c < p / 2;
    case (form)
      0: return c < v;
      1: begin st = (p - v) / 2; return (c >= st) && (c < st + v); end
      2: return right ? (c >= p - v) : (c < v);
      default: return c >= p - v;
    endcase
  endfunction

  // driver-side model: one expected item per clock (R12 capture at period start)
  int mpos = 0;
  int m_form, m_rate;
  logic [DW-1:0] m_sl, m_sr;
  bit m_ml, m_mr, m_zero, m_lrs, m_rs, m_pw;

  always @(posedge clk) begin
    int p, pc, c, vl, vr;
    bit narrow, half, ll, lr;
    logic [1:0] a, b, t;
    if (rst) begin
      mpos = 0;
      expq.delete();
    end else begin
      if (mpos == 0) begin
        m_form = form_sel; m_rate = rate_sel; m_sl = smp_l; m_sr = smp_r;
        m_ml = !spk_mute_n || mute_both || mute_left;
        m_mr = !spk_mute_n || mute_both || mute_right;
        m_zero = zero_mute; m_lrs = lr_swap; m_rs = r_pair_swap; m_pw = power_stage;
      end
      narrow = (m_rate == 1) || (m_rate == 2);
      half   = (m_rate == 1);
      p  = narrow ? 32 : 64;
      pc = half ? 64 : p;
      c  = half ? mpos / 2 : mpos;
      vl = narrow ? int'(m_sl[4:0] ^ 5'h10) : int'(m_sl ^ 6'h20);
      vr = narrow ? int'(m_sr[4:0] ^ 5'h10) : int'(m_sr ^ 6'h20);
      ll = ref_lvl(m_form, 0, vl, p, c, m_ml);
      lr = ref_lvl(m_form, 1, vr, p, c, m_mr);
      a = {ll, ~ll};
      b = {lr, ~lr};
      if (m_lrs) begin t = a; a = b; b = t; end
      if (m_rs && m_pw) b = {b[0], b[1]};
      expq.push_back(m_zero ? 4'b0000 : {a, b});
      mpos = (mpos + 1) % pc;
    end
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (!rst && expq.size() > 0)
      check4(cur_tag, {out_l1, out_l2, out_r1, out_r2}, expq.pop_front());
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check4("R13", {out_l1, out_l2, out_r1, out_r2}, 4'b0000);
    rst = 0;
    cur_tag = "R1";  smp_l = 0; smp_r = 0;                      run(192);
    cur_tag = "R3";  smp_l = 6'd13; smp_r = -6'sd20;            run(192);
    cur_tag = "R4";  form_sel = 1; smp_l = -6'sd31; smp_r = 6'd7; run(192);
    cur_tag = "R4";  smp_l = -6'sd32; smp_r = 6'd31;            run(192);
    cur_tag = "R5";  form_sel = 2; smp_l = 6'd10; smp_r = 6'd10; run(192);
    cur_tag = "R6";  form_sel = 3; smp_l = -6'sd5; smp_r = 6'd20; run(192);
    cur_tag = "R2";  form_sel = 0; rate_sel = 1; smp_l = 6'd5; smp_r = 6'h37; run(192);
    cur_tag = "R2";  rate_sel = 2; form_sel = 1;                run(160);
    cur_tag = "R2";  rate_sel = 3; smp_l = 6'd30;               run(192);
    rate_sel = 0; form_sel = 0; smp_l = 6'd20; smp_r = -6'sd12;
    cur_tag = "R7";  spk_mute_n = 0;                            run(192);
    cur_tag = "R7";  spk_mute_n = 1; mute_both = 1;             run(192);
    cur_tag = "R7";  mute_both = 0; mute_left = 1;              run(192);
    cur_tag = "R7";  mute_left = 0; mute_right = 1;             run(192);
    mute_right = 0;
    cur_tag = "R8";  zero_mute = 1;                             run(192);
    cur_tag = "R9";  zero_mute = 0; form_sel = 2;               run(192);
    cur_tag = "R10"; lr_swap = 1;                               run(192);
    cur_tag = "R11"; r_pair_swap = 1; power_stage = 0;          run(192);
    cur_tag = "R11"; power_stage = 1;                           run(192);
    cur_tag = "R11"; lr_swap = 0;                               run(192);
    cur_tag = "R12"; r_pair_swap = 0; power_stage = 0; form_sel = 0;
    run(64);
    run(20); form_sel = 3; smp_l = -6'sd25; run(17); zero_mute = 1; run(5);
    zero_mute = 0;                                              run(150);
    done = 1;
    finish_run();
  end
endmodule